// File: doc/BRIEF.md
# Per-Channel Sample State Histogram

This block counts how often each of the four possible 2-bit sign-magnitude sample codes appears on each of several parallel sample channels. A later normalisation step needs these counts. Every sample clock cycle, each channel presents one 2-bit code. One shared validity flag qualifies all channels in that cycle. A once-per-second tick closes the counting interval.

Each channel drives a decoder that raises at most one of four hit lines. The raised line advances exactly one of the channel's four saturating counters. When the tick arrives, every counter value is copied into an output snapshot, zero-extended to the output word width, and a one-cycle dump strobe is raised. At the same time each counter restarts. It restarts at one if the tick-cycle sample is valid and lands in that counter's state, and at zero otherwise. No sample is lost at the interval boundary. The snapshot holds steady until the next dump.

Top module: `sample_state_histogram`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears all counters and the snapshot, and holds dump_o low. After that edge, counts_o reads all zeros and dump_o reads 0.
- R2: A valid sample on channel c with code k advances only counter k of channel c, by one. The code is {sign bit, magnitude bit}, and k is the unsigned value of the code (0 to 3).
- R3: A sample whose shared valid flag is low changes no counter.
- R4: A tick at a clock edge makes dump_o high for the following cycle. In that cycle counts_o holds, for every channel c and state k, the number of valid samples in state k since the previous tick or reset, not counting the tick-cycle sample. The count sits in bits [(c*4+k)*OUT_W +: OUT_W], zero-extended from CNT_W bits.
- R5: At a tick edge, counter k of channel c restarts at 1 if that cycle's sample is valid with code k, and at 0 otherwise. Consecutive ticks each produce a dump.
- R6: counts_o changes only in a cycle where dump_o is high. Without a tick, dump_o stays low.
- R7: A counter that reaches 2^CNT_W-1 holds that value until the next tick, and does not wrap.
- R8: Channels count independently. Different codes on different channels in the same cycle each land in their own channel's counters. By default there are 16 channels, 25-bit counters and 32-bit output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | NUM_CH*2 | Channel c code in bits [2c+1:2c], {sign, magnitude} |
| smp_valid_i | input | 1 | Shared per-cycle sample validity |
| sec_tick_i | input | 1 | One-second interval tick |
| dump_o | output | 1 | One-cycle strobe marking a fresh snapshot |
| counts_o | output | NUM_CH*4*OUT_W | Snapshot of all counts, word (c*4+k) for channel c, state k |

## Verification
The bench targets the interval boundary, where a tick coincides with a valid sample. A design that dropped this sample, or counted it into the closing interval, would show a next dump that is off by one in the seeded state. Back-to-back ticks check that a design cannot latch a single strobe per burst or miss the second snapshot. A narrow-counter instance is pushed past its ceiling, which exposes a wrapping counter as a small residue. Invalid-only stretches and held-snapshot windows reveal counting without qualification, or an output that tracks live counters instead of the snapshot.

// File: rtl/ssh_pkg.sv
// Package: shared constants, the sample state type and the code decode
// helper for the sample state histogram.
// Assumes codes are 2-bit {sign, magnitude}; state index equals code value.
package ssh_pkg;

    localparam int STATE_W    = 2;
    localparam int NUM_STATES = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_POS_SMALL = 2'b00,
        ST_POS_LARGE = 2'b01,
        ST_NEG_SMALL = 2'b10,
        ST_NEG_LARGE = 2'b11
    } smp_state_e;

    // Map a state to its one-hot hit vector.
    function automatic logic [NUM_STATES-1:0] state_hit(input smp_state_e st);
        logic [NUM_STATES-1:0] v;
        v = '0;
        v[st] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ssh_decode.sv
// Module: ssh_decode
// Turns one channel's 2-bit code into a one-hot hit vector. The vector is
// all zeros when the sample is not valid. Purely combinational.
module ssh_decode
    import ssh_pkg::*;
(
    input  logic [STATE_W-1:0]    code_i,
    input  logic                  valid_i,
    output logic [NUM_STATES-1:0] hit_o
);

    // Raise the single line for a qualified sample.
    always_comb begin
        hit_o = '0;
        if (valid_i) begin
            hit_o = state_hit(smp_state_e'(code_i));
        end
    end

endmodule

// File: rtl/ssh_bin_counter.sv
// Module: ssh_bin_counter
// One saturating state counter. On restart it reloads with 0 or 1 so that
// the sample arriving with the tick opens the new interval.
// Assumes restart_i is the interval tick and inc_i is the decoded hit.
module ssh_bin_counter #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Count qualified hits, reload on tick, stop at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart_i) begin
            count_q <= inc_i ? CNT_W'(1) : '0;
        end else if (inc_i && (count_q != CNT_MAX)) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

    // R2: a hit below the ceiling advances by exactly one.
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && inc_i && count_o != CNT_MAX) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

    // R3: no hit and no tick leaves the count alone.
    p_no_hit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !inc_i) |=> $stable(count_o));

    // R5: the tick reloads with the tick-cycle hit.
    p_restart_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> count_o == CNT_W'($past(inc_i)));

    // R7: the ceiling is sticky until the next tick.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && count_o == CNT_MAX) |=> count_o == CNT_MAX);

endmodule

// File: rtl/ssh_channel.sv
// Module: ssh_channel
// One channel: a decoder feeding one counter per sample state.
// Assumes the tick and the validity flag are shared by all channels.
module ssh_channel
    import ssh_pkg::*;
#(
    parameter int CNT_W = 25
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [STATE_W-1:0]                code_i,
    input  logic                              valid_i,
    input  logic                              tick_i,
    output logic [NUM_STATES-1:0][CNT_W-1:0]  counts_o
);

    logic [NUM_STATES-1:0] hit;

    ssh_decode u_decode (
        .code_i (code_i),
        .valid_i(valid_i),
        .hit_o  (hit)
    );

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
        ssh_bin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (hit[s]),
            .restart_i(tick_i),
            .count_o  (counts_o[s])
        );
    end

    // R2: a valid sample selects exactly one state line.
    p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> $countones(hit) == 1);

    // R3: an unqualified, tick-free cycle leaves all four counters alone.
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !tick_i) |=> $stable(counts_o));

endmodule

// File: rtl/sample_state_histogram.sv
// Module: sample_state_histogram
// Top: one ssh_channel per input channel plus the snapshot register that
// presents all counts, zero-extended, with a one-cycle dump strobe.
// Assumes OUT_W >= CNT_W and that CNT_W covers one interval of samples.
module sample_state_histogram
    import ssh_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 25,
    parameter int OUT_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CH*STATE_W-1:0]         smp_i,
    input  logic                              smp_valid_i,
    input  logic                              sec_tick_i,
    output logic                              dump_o,
    output logic [NUM_CH*NUM_STATES*OUT_W-1:0] counts_o
);

    localparam int NUM_WORDS = NUM_CH * NUM_STATES;

    logic [NUM_CH-1:0][NUM_STATES-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_WORDS*OUT_W-1:0]                   snap_q;
    logic                                         dump_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ssh_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_i  (smp_i[c*STATE_W +: STATE_W]),
            .valid_i (smp_valid_i),
            .tick_i  (sec_tick_i),
            .counts_o(live_cnt[c])
        );
    end

    // Capture live counts on the tick and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            dump_q <= 1'b0;
        end else begin
            dump_q <= sec_tick_i;
            if (sec_tick_i) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    for (int s = 0; s < NUM_STATES; s++) begin
                        snap_q[(c*NUM_STATES+s)*OUT_W +: OUT_W] <= OUT_W'(live_cnt[c][s]);
                    end
                end
            end
        end
    end

    assign dump_o   = dump_q;
    assign counts_o = snap_q;

    // R4: every tick is followed by a strobe.
    p_dump_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_i |=> dump_o);

    // R6: no tick, no strobe.
    p_no_spurious_dump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick_i |=> !dump_o);

    // R6: the snapshot only moves in a strobe cycle.
    p_snapshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_o |-> $stable(counts_o));

endmodule

// File: tb/sample_state_histogram_tb_top.sv
// Bench: table-driven stimulus checked against a bench-side count model,
// then directed tests for reset, boundary, consecutive ticks and saturation.
module sample_state_histogram_tb_top;

    localparam int NCH   = 16;
    localparam int CW    = 25;
    localparam int OW    = 32;
    localparam int SAT_W = 3;
    localparam int NROWS = 12;
    localparam longint CMAX = (64'd1 << CW) - 1;

    // Row layout: {valid, tick, codes[31:0]}.
    localparam logic [33:0] ROWS [0:NROWS-1] = '{
        34'h2_E4E4E4E4, 34'h2_1B1B1B1B, 34'h0_FFFFFFFF, 34'h2_00000000,
        34'h1_55555555, 34'h2_AAAAAAAA, 34'h0_12345678, 34'h2_0F0F0F0F,
        34'h3_FFFFFFFF, 34'h2_C3C3C3C3, 34'h1_00000000, 34'h2_36363636
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH*2-1:0]     smp = '0;
    logic                 valid = 1'b0;
    logic                 tick = 1'b0;
    logic                 dump;
    logic [NCH*4*OW-1:0]  counts;
    logic                 sat_dump;
    logic [4*OW-1:0]      sat_counts;

    int checks = 0;
    int fails  = 0;
    longint mcnt  [NCH][4];
    longint msnap [NCH][4];
    bit     mdump = 1'b0;

    always #2.5 clk = ~clk;

    sample_state_histogram #(.NUM_CH(NCH), .CNT_W(CW), .OUT_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_valid_i(valid),
        .sec_tick_i(tick), .dump_o(dump), .counts_o(counts)
    );

    sample_state_histogram #(.NUM_CH(1), .CNT_W(SAT_W), .OUT_W(OW)) sat_i (
        .clk(clk), .rst_n(rst_n), .smp_i(smp[1:0]), .smp_valid_i(valid),
        .sec_tick_i(tick), .dump_o(sat_dump), .counts_o(sat_counts)
    );

    // Drive one cycle, advance the model at the edge, settle past it.
    task automatic step(input bit v, input bit t, input logic [31:0] codes);
        @(negedge clk);
        valid = v; tick = t; smp = codes;
        @(posedge clk);
        mdump = t;
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 4; s++) begin
                if (t) begin
                    msnap[c][s] = mcnt[c][s];
                    mcnt[c][s]  = (v && codes[2*c +: 2] == s) ? 1 : 0;
                end else if (v && codes[2*c +: 2] == s && mcnt[c][s] < CMAX) begin
                    mcnt[c][s] = mcnt[c][s] + 1;
                end
            end
        end
        #1;
    endtask

    // Compare the strobe and every snapshot word with the model.
    task automatic check_main(input string req);
        bit bad = 1'b0;
        checks++;
        if (dump !== mdump) begin
            $display("FAIL %s dump_o actual=%0b expected=%0b", req, dump, mdump);
            bad = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 4; s++) begin
                if (!bad && counts[(c*4+s)*OW +: OW] !== OW'(msnap[c][s])) begin
                    $display("FAIL %s ch%0d st%0d actual=%0d expected=%0d",
                             req, c, s, counts[(c*4+s)*OW +: OW], msnap[c][s]);
                    bad = 1'b1;
                end
            end
        end
        if (bad) fails++;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++) begin
                mcnt[c][s] = 0; msnap[c][s] = 0;
            end

        // R1: reset with busy inputs.
        valid = 1'b1; tick = 1'b1; smp = 32'hE4E4E4E4;
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (counts !== '0 || dump !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset dump=%0b counts_nonzero=%0b expected dump=0 counts=0",
                     dump, |counts);
        end
        @(negedge clk);
        rst_n = 1'b1; valid = 1'b0; tick = 1'b0;

        // R2 R3 R4 R5 R6 R8: table walk against the model.
        for (int r = 0; r < NROWS; r++) begin
            step(ROWS[r][33], ROWS[r][32], ROWS[r][31:0]);
            check_main($sformatf("R2/R4/R6/R8 row%0d", r));
        end

        // R4: positional check with explicit values.
        step(1'b0, 1'b1, 32'h0);
        step(1'b1, 1'b0, 32'h00000003);
        step(1'b1, 1'b0, 32'h00000007);
        step(1'b0, 1'b1, 32'h0);
        checks++;
        if (counts[3*OW +: OW] !== 32'd2 || counts[(1*4+1)*OW +: OW] !== 32'd1 ||
            counts[(1*4+0)*OW +: OW] !== 32'd1 || counts[(2*4+0)*OW +: OW] !== 32'd2) begin
            fails++;
            $display("FAIL R4 positions actual=%0d,%0d,%0d,%0d expected=2,1,1,2",
                     counts[3*OW +: OW], counts[(1*4+1)*OW +: OW],
                     counts[(1*4+0)*OW +: OW], counts[(2*4+0)*OW +: OW]);
        end

        // R3: invalid-only interval dumps zeros.
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 32'h9C3A5F17 + i);
        step(1'b0, 1'b1, 32'h0);
        check_main("R3 invalid interval");

        // R6: snapshot holds while live counts move.
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, 32'h6C6C6C6C);
            check_main("R6 hold");
        end

        // R5: tick with valid sample seeds, back-to-back ticks both dump.
        step(1'b1, 1'b1, 32'hE4E4E4E4);
        check_main("R5 first tick");
        step(1'b0, 1'b1, 32'h0);
        check_main("R5 second tick");
        checks++;
        if (counts[(3*4+3)*OW +: OW] !== 32'd1 || counts[(3*4+0)*OW +: OW] !== 32'd0) begin
            fails++;
            $display("FAIL R5 seed actual=%0d/%0d expected=1/0",
                     counts[(3*4+3)*OW +: OW], counts[(3*4+0)*OW +: OW]);
        end

        // R7: narrow instance saturates at 7.
        step(1'b0, 1'b1, 32'h0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'hAAAAAAAA);
        step(1'b0, 1'b1, 32'h0);
        checks++;
        if (sat_counts[2*OW +: OW] !== 32'd7 || sat_counts[0 +: OW] !== 32'd0 ||
            sat_dump !== 1'b1) begin
            fails++;
            $display("FAIL R7 saturate actual=%0d dump=%0b expected=7 dump=1",
                     sat_counts[2*OW +: OW], sat_dump);
        end
        check_main("R7 wide instance unsaturated");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule